// File: doc/BRIEF.md
# System Reset Control Register

This block is a single byte-wide I/O register through which software asks for a system reset and selects which kind of reset it wants. It decodes byte reads and writes at one fixed port address, set by a parameter. When a write carries the trigger bit, the block sends a one-cycle request to the reset sequencer and leaves the stored byte as it was. When a write does not carry the trigger bit, the block keeps only the reset-type selection and clears every other bit.

Reads at the decoded address return the stored byte, so only the type bit can ever read as one. Reads at any other address return zero. A status output is high while the stored byte is nonzero. Save/restore logic uses it to decide whether the register must be captured.

Top module: `sysrst_ctl`

## Requirements
- R1: After a synchronous active-low reset, the stored value is 0x00, `rst_req` is low and `state_nonzero` is low.
- R2: A write at `REG_ADDR` with bit 2 of the data set makes `rst_req` high for exactly one cycle, in the cycle after the write.
- R3: A write with bit 2 set leaves the stored value unchanged.
- R4: A write with bit 2 clear stores data bit 1 in bit 1 and forces all other stored bits to zero. The new value is visible from the next cycle.
- R5: A read at `REG_ADDR` returns the stored value combinationally on `rd_data`, so only bit 1 can be one.
- R6: A write to any other address changes neither the stored value nor `rst_req`. A read at any other address returns 0x00.
- R7: `state_nonzero` is high exactly when the stored value is nonzero.
- R8: `rst_req` is never high in two consecutive cycles unless a trigger write occurred in each preceding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | ADDR_W | I/O port address of the access |
| io_wr | input | 1 | Byte write strobe |
| io_rd | input | 1 | Byte read strobe |
| io_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data (0 unless a read hits the register) |
| rst_req | output | 1 | One-cycle reset request pulse |
| state_nonzero | output | 1 | Stored value is nonzero |

## Verification
The assertions assume that `io_wr` and `io_rd` are never high in the same cycle. They also assume that every access is exactly one byte wide, because the port has no wider access. The bench keeps to these assumptions by driving each access from a task that raises a single strobe for one cycle and then clears it. The bench also drives some writes back to back to exercise the pulse rule across adjacent triggers.

// File: rtl/sysrst_pkg.sv
// Package: shared constants for the reset control register.
// Assumes: byte-wide register; bit positions fixed by software use.
package sysrst_pkg;
    localparam int DATA_W    = 8;
    localparam int TRIG_BIT  = 2;  // write-only trigger
    localparam int TYPE_BIT  = 1;  // retained reset type
    localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << TYPE_BIT;
endpackage

// File: rtl/sysrst_decode.sv
// Module: address decode and write classification.
// Assumes: io_wr and io_rd are single-cycle byte strobes, never both high.
module sysrst_decode #(
    parameter int ADDR_W   = 16,
    parameter int REG_ADDR = 16'h0CF9
) (
    input  logic [ADDR_W-1:0]           io_addr,
    input  logic                        io_wr,
    input  logic                        io_rd,
    input  logic [sysrst_pkg::DATA_W-1:0] io_wdata,
    output logic                        trig_wr,
    output logic                        store_wr,
    output logic                        rd_hit
);
    import sysrst_pkg::*;
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

    logic addr_hit;

    // Classify the current access.
    always_comb begin
        addr_hit = (io_addr == HIT_ADDR);
        trig_wr  = addr_hit && io_wr && io_wdata[TRIG_BIT];
        store_wr = addr_hit && io_wr && !io_wdata[TRIG_BIT];
        rd_hit   = addr_hit && io_rd;
    end
endmodule

// File: rtl/sysrst_store.sv
// Module: retained register holding only the reset-type bit.
// Assumes: store_wr is already qualified by address and trigger bit.
module sysrst_store (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          store_wr,
    input  logic [sysrst_pkg::DATA_W-1:0] io_wdata,
    output logic [sysrst_pkg::DATA_W-1:0] value
);
    import sysrst_pkg::*;

    // Capture the masked write data, or clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        value <= '0;
        else if (store_wr) value <= io_wdata & KEEP_MASK;
    end

    AST_ONLY_TYPE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (value & ~KEEP_MASK) == '0); // R4
    AST_STORE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        store_wr |=> value == ($past(io_wdata) & KEEP_MASK)); // R4
    AST_HOLD_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        !store_wr |=> $stable(value)); // R3
endmodule

// File: rtl/sysrst_pulse.sv
// Module: registers the trigger into a one-cycle reset request.
// Assumes: trig_wr is high only in cycles that carry a trigger write.
module sysrst_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_wr,
    output logic rst_req
);
    // Issue the request one cycle after the trigger write.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= trig_wr;
    end

    AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr |=> rst_req); // R2
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_wr |=> !rst_req); // R8
endmodule

// File: rtl/sysrst_ctl.sv
// Module: top of the system reset control register.
// Assumes: byte accesses only; io_wr and io_rd are never high together.
module sysrst_ctl #(
    parameter int ADDR_W   = 16,
    parameter int REG_ADDR = 16'h0CF9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        rd_data,
    output logic              rst_req,
    output logic              state_nonzero
);
    import sysrst_pkg::*;

    logic              trig_wr;
    logic              store_wr;
    logic              rd_hit;
    logic [DATA_W-1:0] value;

    sysrst_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) dec_i (
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .trig_wr(trig_wr), .store_wr(store_wr), .rd_hit(rd_hit));

    sysrst_store store_i (
        .clk(clk), .rst_n(rst_n), .store_wr(store_wr),
        .io_wdata(io_wdata), .value(value));

    sysrst_pulse pulse_i (
        .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .rst_req(rst_req));

    // Drive read data and the save/restore status.
    always_comb begin
        rd_data       = rd_hit ? value : '0;
        state_nonzero = |value;
    end

    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_rd)); // R6
    AST_TRIG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr |=> $stable(value)); // R3
    AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> rd_data == '0); // R6
    AST_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        state_nonzero == (value != '0)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> value == '0 && !rst_req); // R1
endmodule

// File: tb/sysrst_ctl_tb_top.sv
module sysrst_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam logic [15:0] RA = 16'h0CF9;

    logic              clk = 0;
    logic              rst_n = 0;
    logic [ADDR_W-1:0] io_addr = '0;
    logic              io_wr = 0, io_rd = 0;
    logic [7:0]        io_wdata = '0;
    logic [7:0]        rd_data;
    logic              rst_req, state_nonzero;

    int checks = 0, fails = 0;
    logic [7:0] model = 8'h00;

    sysrst_ctl #(.ADDR_W(ADDR_W), .REG_ADDR(16'h0CF9)) dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one write; at return we are just after the edge that registered it.
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
        @(negedge clk); io_wr = 0; io_wdata = '0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk); io_addr = a; io_rd = 1; #1; d = rd_data;
        @(negedge clk); io_rd = 0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 req", {7'b0, rst_req}, 8'h00);
        chk("R1 nz", {7'b0, state_nonzero}, 8'h00);
        rd(RA, d); chk("R1 value", d, 8'h00);
    endtask

    task automatic t_store();
        logic [7:0] d;
        wr(RA, 8'hFB); model = 8'h02;
        rd(RA, d); chk("R4 mask FB", d, model);
        chk("R7 nz", {7'b0, state_nonzero}, 8'h01);
        wr(RA, 8'hF9); model = 8'h00;
        rd(RA, d); chk("R5 read F9", d, model);
        chk("R7 zero", {7'b0, state_nonzero}, 8'h00);
        wr(RA, 8'h02); model = 8'h02;
        rd(RA, d); chk("R5 read 02", d, model);
    endtask

    task automatic t_trigger();
        logic [7:0] d;
        @(negedge clk); io_addr = RA; io_wdata = 8'h04; io_wr = 1;
        @(negedge clk); io_wr = 0;
        chk("R2 pulse", {7'b0, rst_req}, 8'h01);
        @(negedge clk);
        chk("R2 one cycle", {7'b0, rst_req}, 8'h00);
        rd(RA, d); chk("R3 kept", d, model);
        wr(RA, 8'hFD);
        rd(RA, d); chk("R3 kept FD", d, model);
        // back to back triggers
        @(negedge clk); io_wdata = 8'h04; io_wr = 1;
        @(negedge clk);
        chk("R8 first", {7'b0, rst_req}, 8'h01);
        @(negedge clk); io_wr = 0;
        chk("R8 second", {7'b0, rst_req}, 8'h01);
        @(negedge clk);
        chk("R8 ends", {7'b0, rst_req}, 8'h00);
    endtask

    task automatic t_miss();
        logic [7:0] d;
        wr(16'h0CF8, 8'h00);
        rd(RA, d); chk("R6 miss write", d, model);
        @(negedge clk); io_addr = 16'h0CFA; io_wdata = 8'h04; io_wr = 1;
        @(negedge clk); io_wr = 0;
        chk("R6 miss trig", {7'b0, rst_req}, 8'h00);
        rd(16'h0CF8, d); chk("R6 miss read", d, 8'h00);
        @(negedge clk); io_addr = RA; #1;
        chk("R5 no strobe", rd_data, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_store();
        t_trigger();
        t_miss();
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule